// File: doc/BRIEF.md
# Slot-Linked Call and Return Sequencer

This block is a small fetch engine for a word-addressed machine. It links subroutines without any stack. When it calls a routine at address Z, it stores the return address in memory word Z itself. It then starts the routine at Z+1. The routine returns by branching indirectly through word Z: it reads that word and loads the value into the program counter. The engine talks to an external synchronous word memory through a single request port, and it makes at most one access per cycle.

Only three opcodes carry meaning: the call, the indirect branch and a halt that stops the engine. Every other word is executed as a no-op. This keeps the sequencer useful as a linkage test vehicle inside a larger core. Because each routine has only one slot, a routine that calls itself replaces the outer return address. The outer caller is then never resumed, and this outcome is fully deterministic.

Top module: `slot_link_core`

## Requirements
- R1: While reset is asserted, and for the two cycles after its release needed to synchronise it, `mem_req` and `done` stay low.
- R2: A call at address P with target Z writes the value P+1 into word Z (`mem_req`=1, `mem_we`=1, `mem_addr`=Z, `mem_wdata`=P+1). This happens in the cycle after the call word is decoded.
- R3: The cycle after the call write is an instruction fetch at address Z+1.
- R4: An indirect branch with target Z issues a read of word Z, waits one cycle, and then fetches at the address held in that word.
- R5: The instruction word holds the opcode in bits [31:27] and the target in bits [26:0], zero-extended. Call is 5'h01, indirect branch is 5'h02 and halt is 5'h1F. Every other opcode is a no-op that goes on to the next address.
- R6: Each instruction starts with a one-cycle read request at the program counter. This is followed by one cycle with no request, in which the returned word (valid one cycle after the request) is decoded.
- R7: After a halt word is decoded, `done` is high from the next cycle on, and no further memory request is issued until reset.
- R8: If a routine calls into itself, the nested call overwrites its slot with the inner return address. The original caller's return address is then never fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request for this cycle |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data (return address) |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done | output | 1 | High once a halt has executed |

## Verification
The embedded properties check the local rules on every cycle. They confirm that every write carries the fetch address from two cycles before plus one, that a write is followed directly by a fetch at the slot address plus one, that the address of a branch target comes from the word read just before, that a fetch is followed by an idle decode cycle, and that `done` is terminal. The bench scenarios cover what needs whole programs: that nested calls return through both slots in the right order, that unknown opcodes fall through, and that a self-call leaves the slot holding the inner address so the outer caller is never resumed. A per-cycle reference model compares the full bus trace in each scenario.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int OPW = 5;
  localparam logic [OPW-1:0] OP_CALL = 5'h01;
  localparam logic [OPW-1:0] OP_BRI  = 5'h02;
  localparam logic [OPW-1:0] OP_HALT = 5'h1F;

  typedef enum logic [2:0] {
    S_BOOT, S_FETCH, S_DECODE, S_CALLW, S_BRRD, S_BRLD, S_HALT
  } lk_state_e;

  typedef enum logic [1:0] {K_NOP, K_CALL, K_BRI, K_HALT} lk_kind_e;
endpackage

// File: rtl/link_rst_sync.sv
module link_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/link_decode.sv
module link_decode #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   word_i,
  output link_pkg::lk_kind_e  kind_o
);
  import link_pkg::*;
  logic [OPW-1:0] op;

  assign op = word_i[WORD_W-1 -: OPW];

  always_comb begin
    unique case (op)
      OP_CALL: kind_o = K_CALL;
      OP_BRI:  kind_o = K_BRI;
      OP_HALT: kind_o = K_HALT;
      default: kind_o = K_NOP;
    endcase
  end
endmodule

// File: rtl/link_regs.sv
module link_regs #(
  parameter int          WORD_W    = 32,
  parameter int          FIELD_W   = 27,
  parameter logic [31:0] BOOT_ADDR = 32'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pc_inc_en,
  input  logic               pc_load_en,
  input  logic [WORD_W-1:0]  pc_load_val,
  input  logic               fld_en,
  input  logic [FIELD_W-1:0] fld_d,
  output logic [WORD_W-1:0]  pc_q,
  output logic [FIELD_W-1:0] fld_q
);
  logic [WORD_W-1:0]  pc_d;
  logic [FIELD_W-1:0] fld_nx;

  always_comb begin
    if (pc_load_en)     pc_d = pc_load_val;
    else if (pc_inc_en) pc_d = pc_q + WORD_W'(1);
    else                pc_d = pc_q;
  end

  always_comb fld_nx = fld_en ? fld_d : fld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= WORD_W'(BOOT_ADDR);
      fld_q <= '0;
    end else begin
      pc_q  <= pc_d;
      fld_q <= fld_nx;
    end
  end
endmodule

// File: rtl/link_ctrl.sv
module link_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  link_pkg::lk_kind_e  kind_i,
  output logic                req_o,
  output logic                we_o,
  output logic                use_tgt_o,
  output logic                pc_inc_o,
  output logic                pc_load_o,
  output logic                pc_from_mem_o,
  output logic                fld_load_o,
  output logic                done_o,
  output link_pkg::lk_state_e state_o
);
  import link_pkg::*;
  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_BOOT:   st_d = S_FETCH;
      S_FETCH:  st_d = S_DECODE;
      S_DECODE: begin
        unique case (kind_i)
          K_CALL:  st_d = S_CALLW;
          K_BRI:   st_d = S_BRRD;
          K_HALT:  st_d = S_HALT;
          default: st_d = S_FETCH;
        endcase
      end
      S_CALLW:  st_d = S_FETCH;
      S_BRRD:   st_d = S_BRLD;
      S_BRLD:   st_d = S_FETCH;
      S_HALT:   st_d = S_HALT;
      default:  st_d = S_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_BOOT;
    else        st_q <= st_d;
  end

  always_comb begin
    req_o         = (st_q == S_FETCH) || (st_q == S_CALLW) || (st_q == S_BRRD);
    we_o          = (st_q == S_CALLW);
    use_tgt_o     = (st_q == S_CALLW) || (st_q == S_BRRD);
    pc_inc_o      = (st_q == S_DECODE);
    fld_load_o    = (st_q == S_DECODE);
    pc_load_o     = (st_q == S_CALLW) || (st_q == S_BRLD);
    pc_from_mem_o = (st_q == S_BRLD);
    done_o        = (st_q == S_HALT);
  end

  assign state_o = st_q;
endmodule

// File: rtl/slot_link_core.sv
module slot_link_core #(
  parameter int          WORD_W    = 32,
  parameter logic [31:0] BOOT_ADDR = 32'd0,
  parameter int          SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done
);
  import link_pkg::*;
  localparam int FIELD_W = WORD_W - OPW;

  logic               rst_i_n;
  lk_kind_e           kind;
  lk_state_e          st;
  logic               use_tgt, pc_inc, pc_load, pc_from_mem, fld_load;
  logic [WORD_W-1:0]  pc_q, pc_load_val, tgt_ext;
  logic [FIELD_W-1:0] fld_q;

  link_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  link_decode #(.WORD_W(WORD_W)) u_dec (.word_i(mem_rdata), .kind_o(kind));

  link_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .kind_i(kind),
    .req_o(mem_req), .we_o(mem_we), .use_tgt_o(use_tgt),
    .pc_inc_o(pc_inc), .pc_load_o(pc_load), .pc_from_mem_o(pc_from_mem),
    .fld_load_o(fld_load), .done_o(done), .state_o(st));

  link_regs #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .BOOT_ADDR(BOOT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .pc_inc_en(pc_inc), .pc_load_en(pc_load), .pc_load_val(pc_load_val),
    .fld_en(fld_load), .fld_d(mem_rdata[FIELD_W-1:0]),
    .pc_q(pc_q), .fld_q(fld_q));

  assign tgt_ext     = {{OPW{1'b0}}, fld_q};
  assign pc_load_val = pc_from_mem ? mem_rdata : tgt_ext + WORD_W'(1);
  assign mem_addr    = use_tgt ? tgt_ext : pc_q;
  assign mem_wdata   = pc_q;

  // R2: stored link value is the fetch address two cycles earlier plus one
  p_ret_addr_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && mem_we) |-> mem_wdata == $past(mem_addr, 2) + WORD_W'(1));

  // R3: the write is followed by a fetch just past the slot
  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && mem_we) |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + WORD_W'(1)));

  // R4: fetch after an indirect branch goes where the slot word pointed
  p_branch_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == S_BRLD) |=> (mem_req && !mem_we && mem_addr == $past(mem_rdata)));

  // R6: a fetch request is followed by an idle decode cycle
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == S_FETCH) |=> !mem_req);

  // R7: done is terminal and silences the memory port
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> (done && !mem_req));
endmodule

// File: tb/test_slot_link_core.sv
`timescale 1ns/1ps
module test_slot_link_core;
  logic        clk, rst_n;
  logic        mem_req, mem_we, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  slot_link_core #(.WORD_W(32), .BOOT_ADDR(32'd100), .SYNC_LEN(2)) i_slot_link_core (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] sm  [0:1023];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  typedef struct {
    bit req; bit we; logic [31:0] addr; logic [31:0] wdata; bit dn; string tag;
  } exp_t;
  exp_t q[$];

  int    n_checks = 0, n_fail = 0;
  logic [31:0] mp;
  bit    halted;
  string next_tag;
  int    watch;
  bit    seen;

  function automatic logic [31:0] mk(logic [4:0] op, int a);
    logic [31:0] t;
    t = a;
    return {op, t[26:0]};
  endfunction

  task automatic push(bit rq, bit w, logic [31:0] a, logic [31:0] d, bit dn, string tg);
    exp_t e;
    e.req = rq; e.we = w; e.addr = a; e.wdata = d; e.dn = dn; e.tag = tg;
    q.push_back(e);
  endtask

  task automatic model_step();
    logic [31:0] ins, z;
    if (halted) begin
      push(0, 0, 0, 0, 1, "R7");
      return;
    end
    ins = sm[mp[9:0]];
    push(1, 0, mp, 0, 0, next_tag);
    push(0, 0, 0, 0, 0, "R6");
    z = {5'b0, ins[26:0]};
    case (ins[31:27])
      5'h01: begin
        push(1, 1, z, mp + 1, 0, "R2");
        sm[z[9:0]] = mp + 1;
        mp = z + 1;
        next_tag = "R3";
      end
      5'h02: begin
        push(1, 0, z, 0, 0, "R4");
        push(0, 0, 0, 0, 0, "R4");
        mp = sm[z[9:0]];
        next_tag = "R4";
      end
      5'h1F: halted = 1;
      default: begin
        mp = mp + 1;
        next_tag = "R5";
      end
    endcase
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic compare_cycle();
    exp_t e;
    bit ok;
    if (q.size() == 0) model_step();
    e = q.pop_front();
    ok = (mem_req === e.req) && (done === e.dn);
    if (e.req) ok = ok && (mem_we === e.we) && (mem_addr === e.addr);
    if (e.req && e.we) ok = ok && (mem_wdata === e.wdata);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s bus: actual req=%b we=%b addr=%h wd=%h done=%b expected req=%b we=%b addr=%h wd=%h done=%b",
               e.tag, mem_req, mem_we, mem_addr, mem_wdata, done,
               e.req, e.we, e.addr, e.wdata, e.dn);
    end
    if (mem_req && !mem_we && mem_addr == watch) seen = 1;
  endtask

  task automatic poke(int a, logic [31:0] v);
    mem[a] = v;
    sm[a]  = v;
  endtask

  task automatic start_scenario();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = '0;
      sm[i]  = '0;
    end
    q.delete();
    mp = 32'd100; halted = 0; next_tag = "R6"; seen = 0;
  endtask

  task automatic release_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mem_req && !done, "R1", "quiet in reset", {30'b0, mem_req, done}, 32'd0);
    end
    rst_n = 1'b1;
    push(0, 0, 0, 0, 0, "R1");
    push(0, 0, 0, 0, 0, "R1");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_cycle();
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;

    // Scenario A: plain call and return (R2, R3, R4, R7)
    start_scenario();
    poke(100, mk(5'h01, 200));
    poke(101, mk(5'h1F, 0));
    poke(201, mk(5'h00, 0));
    poke(202, mk(5'h02, 200));
    watch = 101;
    release_reset();
    run(40);
    chk(mem[200] == 32'd101, "R2", "slot 200", mem[200], 32'd101);
    chk(seen, "R4", "returned to 101", {31'b0, seen}, 32'd1);
    chk(done, "R7", "done after halt", {31'b0, done}, 32'd1);

    // Scenario B: nested two-level call with unknown opcodes (R5, R2, R4)
    start_scenario();
    poke(100, mk(5'h07, 55));
    poke(101, mk(5'h01, 300));
    poke(102, mk(5'h1F, 0));
    poke(301, mk(5'h01, 400));
    poke(302, mk(5'h02, 300));
    poke(401, mk(5'h13, 0));
    poke(402, mk(5'h02, 400));
    watch = 102;
    release_reset();
    run(60);
    chk(mem[300] == 32'd102, "R2", "outer slot", mem[300], 32'd102);
    chk(mem[400] == 32'd302, "R2", "inner slot", mem[400], 32'd302);
    chk(seen, "R4", "unwound to 102", {31'b0, seen}, 32'd1);
    chk(done, "R7", "done after nested", {31'b0, done}, 32'd1);

    // Scenario C: routine at 200 re-enters itself once through a helper (R8)
    start_scenario();
    poke(100, mk(5'h01, 200));
    poke(101, mk(5'h1F, 0));
    poke(201, mk(5'h02, 250));
    poke(250, 32'd202);
    poke(202, mk(5'h01, 250));
    poke(251, mk(5'h01, 200));
    poke(203, mk(5'h02, 200));
    poke(252, mk(5'h02, 200));
    watch = 101;
    release_reset();
    run(300);
    chk(mem[200] == 32'd252, "R8", "slot overwritten", mem[200], 32'd252);
    chk(!seen, "R8", "caller 101 never fetched", {31'b0, seen}, 32'd0);
    chk(!done, "R8", "no halt reached", {31'b0, done}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule